// File: doc/BRIEF.md
# Serial-Read Converter Interface with Frame-Length Power Control

This block is the digital front of a small sampling converter that is read over a three-wire serial port: an active-low select, a serial clock and a serial data output. There is no data input and no mode register. The host picks the operating mode only by how many serial clock falling edges it gives before it releases select. A short frame of middling length puts the converter to sleep. A longer frame given while asleep wakes it. A full frame returns a sample. The 12-bit sample comes in on a parallel input that stands in for the analog core. The block latches it when select falls and shifts it out behind a fixed run of zero bits.

All port activity is sampled on the system clock `clk`. Edges of select and serial clock are found by comparing each input with its value at the previous clock edge. The power-state machine has five states. `ST_UP_IDLE` is powered with select high. `ST_UP_FRAME` is powered inside a frame. `ST_DN_IDLE` is asleep with select high. `ST_DN_FRAME` is a wake-up frame in progress. `ST_AUTO_DONE` is used only in the automatic variant: the sixteenth edge has passed and the block waits for select to rise.

The transitions are named as follows. *start* (`ST_UP_IDLE` to `ST_UP_FRAME`, or `ST_DN_IDLE` to `ST_DN_FRAME`) happens on a select fall. *sleep* (`ST_UP_FRAME` to `ST_DN_IDLE`) happens on a select rise after 2 to 9 falling edges. *finish* (`ST_UP_FRAME` to `ST_UP_IDLE`) happens on any other select rise. *wake* (`ST_DN_FRAME` to `ST_UP_IDLE`) happens on a select rise after 10 or more edges. *stay-asleep* (`ST_DN_FRAME` to `ST_DN_IDLE`) happens on a select rise after fewer edges.

With `AUTO_PD=1`, the automatic variant uses a different set of transitions. *auto-start* (`ST_DN_IDLE` to `ST_UP_FRAME`) happens on a select fall. *auto-done* (`ST_UP_FRAME` to `ST_AUTO_DONE`) happens on the sixteenth falling edge. *auto-release* (`ST_AUTO_DONE` to `ST_DN_IDLE`) and *auto-abort* (`ST_UP_FRAME` to `ST_DN_IDLE`) both happen on a select rise.

Top module: `adc_spi_pdctl`

## Requirements
- R1: After reset, `pwr_up` is 1 and `sdata_oe`, `frame_ok` and `conv_start` are 0.
- R2: A fall of `cs_n` gives a `conv_start` pulse exactly one clock long. The same fall drives `sdata` to 0, the first leading zero, with `sdata_oe` at 1.
- R3: A frame is 16 bits: four zeros, then the 12-bit `sample_in` value latched at the select fall, most significant bit first. Each `sclk` falling edge advances `sdata` by one bit, so the bit present just before falling edge k (k=1..16) is bit 16-k of the word.
- R4: While `cs_n` is high, `sdata_oe` is 0, which means the data line is in high impedance.
- R5: In powered mode, a rise of `cs_n` after 2 to 9 `sclk` falling edges sets `pwr_up` to 0 (sleep) and gives no `frame_ok`.
- R6: A rise of `cs_n` after fewer than 2 falling edges leaves `pwr_up` unchanged, whether the block is powered or asleep.
- R7: In powered mode, `frame_ok` pulses for one clock on the `cs_n` rise only if 16 falling edges occurred. After 10 to 15 edges the block stays powered and gives no `frame_ok`.
- R8: While asleep, a frame of 10 or more falling edges is a dummy frame. It sets `pwr_up` to 1 and gives no `frame_ok`. A frame of 2 to 9 edges leaves the block asleep.
- R9: With `AUTO_PD=1`, `pwr_up` is 1 from the select fall until the sixteenth falling edge, and then 0. Every frame ends asleep, and `frame_ok` pulses only after 16 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all port activity |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; frames a conversion |
| sclk | input | 1 | Serial clock, idles high |
| sample_in | input | DATA_W | Parallel sample from the converter core |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for `sdata`; 0 means high impedance |
| pwr_up | output | 1 | 1 when the converter is powered |
| frame_ok | output | 1 | One-clock pulse when a frame delivered a valid sample |
| conv_start | output | 1 | One-clock pulse when a conversion begins |

## Verification
Every result registers on the first `clk` rising edge that sees the input change. The bench changes `cs_n` and `sclk` only on falling `clk` edges and reads outputs at the next falling edge, half a period after that rising edge. `conv_start` and `frame_ok` are checked high in that one cycle and low in the next. The serial scoreboard compares `sdata` at the instant the bench drops `sclk`. At that moment the line still holds the bit produced by the previous edge, so bit 16-k is compared at falling edge k. The automatic variant runs in parallel on the same stimulus. Its power flag is checked one cycle after the sixteenth edge and again after the select rise.

// File: rtl/adcsio_pkg.sv
package adcsio_pkg;

    typedef enum logic [2:0] {
        ST_UP_IDLE,
        ST_UP_FRAME,
        ST_DN_IDLE,
        ST_DN_FRAME,
        ST_AUTO_DONE
    } pm_state_t;

endpackage

// File: rtl/adcsio_edge.sv
module adcsio_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_fall,
    output logic cs_low_q
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    always_comb begin
        cs_fall   = cs_q & ~cs_n;
        cs_rise   = ~cs_q & cs_n;
        sclk_fall = sclk_q & ~sclk & ~cs_q & ~cs_n;
        cs_low_q  = ~cs_q;
    end

endmodule

// File: rtl/adcsio_shift.sv
module adcsio_shift #(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4,
    localparam int FRAME_LEN = DATA_W + LEAD_ZEROS,
    localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] sample_in,
    output logic [CNT_W-1:0]  fall_cnt,
    output logic              sdata
);
    logic [FRAME_LEN-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            fall_cnt <= '0;
        end else if (cs_fall) begin
            shreg    <= {{LEAD_ZEROS{1'b0}}, sample_in};
            fall_cnt <= '0;
        end else if (sclk_fall) begin
            shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
            if (fall_cnt < CNT_W'(FRAME_LEN))
                fall_cnt <= fall_cnt + 1'b1;
        end
    end

    assign sdata = shreg[FRAME_LEN-1];

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_cnt < CNT_W'(LEAD_ZEROS)) |-> !sdata);

endmodule

// File: rtl/adcsio_mode.sv
module adcsio_mode
    import adcsio_pkg::*;
#(
    parameter bit AUTO_PD   = 1'b0,
    parameter int FRAME_LEN = 16,
    parameter int PD_FIRST  = 2,
    parameter int PD_LAST   = 10,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_fall,
    input  logic [CNT_W-1:0] fall_cnt,
    output logic             pwr_up,
    output logic             frame_ok,
    output logic             conv_start
);
    pm_state_t st_q, st_nx;
    logic      ok_nx;
    logic      in_pd_win, wake_ok, full, last_fall;

    always_comb begin
        in_pd_win = (fall_cnt >= CNT_W'(PD_FIRST)) && (fall_cnt < CNT_W'(PD_LAST));
        wake_ok   = fall_cnt >= CNT_W'(PD_LAST);
        full      = fall_cnt == CNT_W'(FRAME_LEN);
        last_fall = sclk_fall && (fall_cnt == CNT_W'(FRAME_LEN - 1));
    end

    always_comb begin
        st_nx = st_q;
        ok_nx = 1'b0;
        unique case (st_q)
            ST_UP_IDLE: begin
                if (cs_fall) st_nx = ST_UP_FRAME;
            end
            ST_UP_FRAME: begin
                if (AUTO_PD) begin
                    if (last_fall)    st_nx = ST_AUTO_DONE;
                    else if (cs_rise) st_nx = ST_DN_IDLE;
                end else if (cs_rise) begin
                    st_nx = in_pd_win ? ST_DN_IDLE : ST_UP_IDLE;
                    ok_nx = full;
                end
            end
            ST_DN_IDLE: begin
                if (cs_fall) st_nx = AUTO_PD ? ST_UP_FRAME : ST_DN_FRAME;
            end
            ST_DN_FRAME: begin
                if (cs_rise) st_nx = wake_ok ? ST_UP_IDLE : ST_DN_IDLE;
            end
            ST_AUTO_DONE: begin
                if (cs_rise) begin
                    st_nx = ST_DN_IDLE;
                    ok_nx = 1'b1;
                end
            end
            default: st_nx = ST_UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_UP_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_up     <= 1'b1;
            frame_ok   <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            pwr_up     <= (st_nx == ST_UP_IDLE) || (st_nx == ST_UP_FRAME);
            frame_ok   <= ok_nx;
            conv_start <= cs_fall;
        end
    end

    // R7
    frame_ok_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> ($past(fall_cnt) == CNT_W'(FRAME_LEN)));

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    generate
        if (AUTO_PD) begin : g_auto
            // R9
            auto_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (last_fall && st_q == ST_UP_FRAME) |=> !pwr_up);
        end else begin : g_manual
            // R5
            pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_UP_FRAME && cs_rise && in_pd_win) |=> !pwr_up);
            // R6
            short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cs_rise && fall_cnt < CNT_W'(PD_FIRST)) |=> (pwr_up == $past(pwr_up)));
        end
    endgenerate

endmodule

// File: rtl/adc_spi_pdctl.sv
module adc_spi_pdctl #(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int PD_FIRST   = 2,
    parameter int PD_LAST    = 10,
    parameter bit AUTO_PD    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              pwr_up,
    output logic              frame_ok,
    output logic              conv_start
);
    localparam int FRAME_LEN = DATA_W + LEAD_ZEROS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic             cs_fall, cs_rise, sclk_fall, cs_low_q;
    logic [CNT_W-1:0] fall_cnt;

    adcsio_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_fall (sclk_fall),
        .cs_low_q  (cs_low_q)
    );

    adcsio_shift #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .sample_in (sample_in),
        .fall_cnt  (fall_cnt),
        .sdata     (sdata)
    );

    adcsio_mode #(
        .AUTO_PD   (AUTO_PD),
        .FRAME_LEN (FRAME_LEN),
        .PD_FIRST  (PD_FIRST),
        .PD_LAST   (PD_LAST)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_fall  (sclk_fall),
        .fall_cnt   (fall_cnt),
        .pwr_up     (pwr_up),
        .frame_ok   (frame_ok),
        .conv_start (conv_start)
    );

    assign sdata_oe = cs_low_q;

    // R4
    hiz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !sdata_oe);

    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (!sdata && sdata_oe));

endmodule

// File: tb/adc_spi_pdctl_tb.sv
module adc_spi_pdctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample_in = '0;

    logic sdata, sdata_oe, pwr_up, frame_ok, conv_start;
    logic a_sdata, a_oe, a_pwr, a_fok, a_cs;

    int tests = 0;
    int fails = 0;
    logic exp_q[$];
    logic exp_pwr = 1'b1;

    always #4 clk = ~clk;

    adc_spi_pdctl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
        .sdata(sdata), .sdata_oe(sdata_oe), .pwr_up(pwr_up),
        .frame_ok(frame_ok), .conv_start(conv_start)
    );

    adc_spi_pdctl #(.AUTO_PD(1'b1)) u_dut_auto (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
        .sdata(a_sdata), .sdata_oe(a_oe), .pwr_up(a_pwr),
        .frame_ok(a_fok), .conv_start(a_cs)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: R3 bit order, compared when the host drops sclk
    always @(negedge sclk) begin
        if (!cs_n && exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            chk("R3 serial bit", {15'd0, sdata}, {15'd0, e});
        end
    end

    task automatic frame(input int n, input logic [11:0] val, input string tag);
        logic start_pwr;
        logic [15:0] word;
        start_pwr = exp_pwr;
        sample_in = val;
        word = {4'b0000, val};
        if (n == 16 && start_pwr)
            for (int b = 15; b >= 0; b--) exp_q.push_back(word[b]);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk("R2 conv_start", {15'd0, conv_start}, 16'd1);
        chk("R2 first zero", {15'd0, sdata}, 16'd0);
        chk("R2 oe on", {15'd0, sdata_oe}, 16'd1);
        chk("R9 auto wake at start", {15'd0, a_pwr}, 16'd1);
        for (int i = 1; i <= n; i++) begin
            sclk = 1'b0;
            @(negedge clk);
            if (i == 16) chk("R9 auto sleep at edge 16", {15'd0, a_pwr}, 16'd0);
            sclk = 1'b1;
            @(negedge clk);
        end
        cs_n = 1'b1;
        if (start_pwr) begin
            if (n >= 2 && n < 10) exp_pwr = 1'b0;
        end else begin
            if (n >= 10) exp_pwr = 1'b1;
        end
        @(negedge clk);
        chk(tag, {15'd0, pwr_up}, {15'd0, exp_pwr});
        chk("R7 frame_ok", {15'd0, frame_ok}, {15'd0, (start_pwr && n == 16)});
        chk("R4 oe off", {15'd0, sdata_oe}, 16'd0);
        chk("R9 auto ends asleep", {15'd0, a_pwr}, 16'd0);
        chk("R9 auto frame_ok", {15'd0, a_fok}, {15'd0, (n == 16)});
        @(negedge clk);
        chk("R7 frame_ok one cycle", {15'd0, frame_ok}, 16'd0);
        chk("R2 conv_start one cycle", {15'd0, conv_start}, 16'd0);
        chk("R3 scoreboard drained", exp_q.size() > 0 ? 16'd1 : 16'd0, 16'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwr_up", {15'd0, pwr_up}, 16'd1);
        chk("R1 oe", {15'd0, sdata_oe}, 16'd0);
        chk("R1 frame_ok", {15'd0, frame_ok}, 16'd0);
        chk("R1 conv_start", {15'd0, conv_start}, 16'd0);
        chk("R1 auto pwr_up", {15'd0, a_pwr}, 16'd1);

        frame(16, 12'hA5C, "R3 powered after full frame");
        frame(16, 12'h3C1, "R3 powered after full frame");
        frame(1,  12'h111, "R6 short frame keeps power");
        frame(0,  12'h222, "R6 empty frame keeps power");
        frame(15, 12'h333, "R7 15 edges stay powered");
        frame(10, 12'h444, "R7 10 edges stay powered");
        frame(2,  12'h555, "R5 2 edges sleep");
        frame(1,  12'h666, "R6 short frame keeps sleep");
        frame(9,  12'h777, "R8 9 edges stay asleep");
        frame(10, 12'h888, "R8 10 edges wake");
        frame(9,  12'h999, "R5 9 edges sleep");
        frame(16, 12'hBBB, "R8 dummy frame wakes");
        frame(16, 12'hFFF, "R3 powered after full frame");
        frame(16, 12'h001, "R3 powered after full frame");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule